// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the byte-wide register front end of an SMBus host adapter. A host bus reads and writes seven byte registers: status, control, command, target address, two data bytes and a port into a 32-byte block buffer. Writing the control register with its go bit asks a separate transaction engine to run one SMBus transfer. The engine's completion or failure is folded back into sticky status flags, and any returned data lands in the data registers.

A small transfer state machine owns the engine handshake. Its states are XS_IDLE (no transfer), XS_LAUNCH (one-cycle start pulse to the engine), XS_WAIT (engine running, busy shown) and XS_ABORT (transfer refused, one cycle). Its transitions are:
- go from XS_IDLE to XS_LAUNCH, when no error is pending and the protocol code is supported;
- go from XS_IDLE to XS_ABORT, when an error is pending or the protocol code is unsupported;
- XS_LAUNCH to XS_WAIT, always;
- XS_WAIT to XS_IDLE, on engine done or engine error;
- XS_ABORT to XS_IDLE, always.

Register writes take effect at the clock edge that samples the write strobe. Read data is registered: it appears on `rd_data` after the edge that samples the read strobe and holds until the next read.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, every register, the block buffer and its index are zero, `rd_data` is 0 and `seq_start` is low.
- R2: The register offsets are status 0x00, control 0x02, command 0x03, target address 0x04, data-low 0x05, data-high 0x06 and block port 0x07. Command, address and both data registers read back what was written. Any other offset reads 0, and writes to it change nothing.
- R3: Writing status clears each flag whose written bit is 1 and leaves the others alone. The flags are interrupt (bit 1), device error (bit 2) and byte done (bit 7). Bit 0 shows busy and cannot be cleared this way. Bits 3 to 6 read 0.
- R4: Control keeps the whole written byte, but a control read returns only bits [4:0]. Bits [7:5] read 0.
- R5: A control write with bit 6 set, while the block is idle, sets busy at that edge and drives `seq_start` high for exactly the next cycle. A go while busy starts nothing.
- R6: Busy stays set until the engine reports done or error, and clears at that edge.
- R7: Done without error sets byte done (bit 7) and interrupt (bit 1). With `seq_ld_lo` set, data-low is loaded from `seq_rdata[7:0]`. With `seq_ld_hi` set, data-high is loaded from `seq_rdata[15:8]`.
- R8: An engine error sets device error (bit 2), even if done is raised in the same cycle, and no data is loaded.
- R9: A go issued while device error is set raises no `seq_start`. Busy clears after one cycle and device error stays set.
- R10: A go with protocol code control[4:2] equal to 4, 6 or 7 raises no `seq_start` and sets device error. Codes 0, 1, 2, 3 and 5 start the engine.
- R11: Each access to the block port reads or writes the entry at the buffer index, then advances the index. The index wraps from 31 to 0.
- R12: A status write or a control read resets the block index to 0.
- R13: The engine sees the protocol code as control[4:2], read/write as address[0], the 7-bit target as address[7:1], the command byte, and `{data-high, data-low}` as its 16-bit write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (ignored when wr_en is high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| seq_start | output | 1 | One-cycle request to the transaction engine |
| seq_prot | output | 3 | Protocol code |
| seq_rnw | output | 1 | 1 = read transfer |
| seq_taddr | output | 7 | Target device address |
| seq_cmd | output | 8 | Command byte |
| seq_wdata | output | 16 | Outgoing data {high, low} |
| seq_done | input | 1 | Engine finished |
| seq_err | input | 1 | Engine failed |
| seq_rdata | input | 16 | Returned data |
| seq_ld_lo | input | 1 | Load data-low on done |
| seq_ld_hi | input | 1 | Load data-high on done |

## Verification
If the transfer state machine lands in the wrong state, it shows within one cycle: `seq_start` goes missing or repeats, or busy stays stuck in the status byte on the next status read. A wrong block index shows at the first block read after a rewind, as data from the wrong entry. A lost or misplaced sticky flag shows on the next status read, since every transfer ends with one.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    // register offsets
    localparam int OFS_STAT  = 0;
    localparam int OFS_CTL   = 2;
    localparam int OFS_CMD   = 3;
    localparam int OFS_TADDR = 4;
    localparam int OFS_DLO   = 5;
    localparam int OFS_DHI   = 6;
    localparam int OFS_BLK   = 7;

    // status bit positions
    localparam int ST_BUSY   = 0;
    localparam int ST_INTR   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_BDONE  = 7;

    localparam int CTL_GO    = 6;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_LAUNCH,
        XS_WAIT,
        XS_ABORT
    } xfer_state_t;

    function automatic logic prot_supported(input logic [2:0] code);
        return (code <= 3'd3) || (code == 3'd5);
    endfunction
endpackage

// File: rtl/smbh_xfer_fsm.sv
module smbh_xfer_fsm import smbh_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic err_pending,
    input  logic prot_ok,
    input  logic seq_done,
    input  logic seq_err,
    output logic busy,
    output logic seq_start,
    output logic set_ok,
    output logic set_fail
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: begin
                if (go) state_d = (err_pending || !prot_ok) ? XS_ABORT : XS_LAUNCH;
            end
            XS_LAUNCH: state_d = XS_WAIT;
            XS_WAIT: begin
                if (seq_done || seq_err) state_d = XS_IDLE;
            end
            XS_ABORT: state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != XS_IDLE);
        seq_start = (state_q == XS_LAUNCH);
        set_ok    = (state_q == XS_WAIT) && seq_done && !seq_err;
        set_fail  = ((state_q == XS_WAIT) && seq_err) || (state_q == XS_ABORT);
    end
endmodule

// File: rtl/smbh_status_reg.sv
module smbh_status_reg import smbh_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_we,
    input  logic [7:0] clr_mask,
    input  logic       busy,
    input  logic       set_ok,
    input  logic       set_fail,
    output logic [7:0] stat
);
    localparam logic [7:0] HELD = (8'd1 << ST_INTR) | (8'd1 << ST_DEVERR) | (8'd1 << ST_BDONE);

    logic [7:0] held_q, keep_v, set_v;

    always_comb begin
        set_v            = '0;
        set_v[ST_INTR]   = set_ok;
        set_v[ST_BDONE]  = set_ok;
        set_v[ST_DEVERR] = set_fail;
        keep_v           = clr_we ? (held_q & ~clr_mask) : held_q;
    end

    // hardware set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= (keep_v | set_v) & HELD;
    end

    assign stat = held_q | {7'b0, busy};
endmodule

// File: rtl/smbh_blk_buf.sv
module smbh_blk_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     rd,
    input  logic                     rewind,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr) begin
            mem[idx_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         idx_q <= '0;
        else if (rewind)    idx_q <= '0;
        else if (wr || rd)  idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    assign rdata = mem[idx_q];
    assign idx   = idx_q;
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs import smbh_pkg::*; #(
    parameter int ADDR_W    = 8,
    parameter int BLK_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              seq_start,
    output logic [2:0]        seq_prot,
    output logic              seq_rnw,
    output logic [6:0]        seq_taddr,
    output logic [7:0]        seq_cmd,
    output logic [15:0]       seq_wdata,
    input  logic              seq_done,
    input  logic              seq_err,
    input  logic [15:0]       seq_rdata,
    input  logic              seq_ld_lo,
    input  logic              seq_ld_hi
);
    localparam int IDX_W = $clog2(BLK_DEPTH);

    logic wr_act, rd_act;
    logic hit_stat, hit_ctl, hit_cmd, hit_taddr, hit_dlo, hit_dhi, hit_blk;
    logic [7:0] ctl_q, cmd_q, taddr_q, dlo_q, dhi_q;
    logic [7:0] stat_w, blk_rdata, rd_next;
    logic [IDX_W-1:0] blk_idx;
    logic busy, set_ok, set_fail, go;
    logic unused_ctl;

    assign wr_act    = wr_en;
    assign rd_act    = rd_en & ~wr_en;
    assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    assign hit_ctl   = (bus_addr == ADDR_W'(OFS_CTL));
    assign hit_cmd   = (bus_addr == ADDR_W'(OFS_CMD));
    assign hit_taddr = (bus_addr == ADDR_W'(OFS_TADDR));
    assign hit_dlo   = (bus_addr == ADDR_W'(OFS_DLO));
    assign hit_dhi   = (bus_addr == ADDR_W'(OFS_DHI));
    assign hit_blk   = (bus_addr == ADDR_W'(OFS_BLK));

    assign go = wr_act && hit_ctl && wr_data[CTL_GO];

    smbh_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .err_pending(stat_w[ST_DEVERR]),
        .prot_ok    (prot_supported(wr_data[4:2])),
        .seq_done   (seq_done),
        .seq_err    (seq_err),
        .busy       (busy),
        .seq_start  (seq_start),
        .set_ok     (set_ok),
        .set_fail   (set_fail)
    );

    smbh_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_we  (wr_act && hit_stat),
        .clr_mask(wr_data),
        .busy    (busy),
        .set_ok  (set_ok),
        .set_fail(set_fail),
        .stat    (stat_w)
    );

    smbh_blk_buf #(.DEPTH(BLK_DEPTH), .W(8)) u_blk (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_act && hit_blk),
        .rd    (rd_act && hit_blk),
        .rewind((wr_act && hit_stat) || (rd_act && hit_ctl)),
        .wdata (wr_data),
        .rdata (blk_rdata),
        .idx   (blk_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            cmd_q   <= '0;
            taddr_q <= '0;
        end else if (wr_act) begin
            if (hit_ctl)   ctl_q   <= wr_data;
            if (hit_cmd)   cmd_q   <= wr_data;
            if (hit_taddr) taddr_q <= wr_data;
        end
    end

    // engine return data takes priority over a host write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlo_q <= '0;
            dhi_q <= '0;
        end else begin
            if (set_ok && seq_ld_lo)       dlo_q <= seq_rdata[7:0];
            else if (wr_act && hit_dlo)    dlo_q <= wr_data;
            if (set_ok && seq_ld_hi)       dhi_q <= seq_rdata[15:8];
            else if (wr_act && hit_dhi)    dhi_q <= wr_data;
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_stat)  rd_next = stat_w;
        if (hit_ctl)   rd_next = {3'b000, ctl_q[4:0]};
        if (hit_cmd)   rd_next = cmd_q;
        if (hit_taddr) rd_next = taddr_q;
        if (hit_dlo)   rd_next = dlo_q;
        if (hit_dhi)   rd_next = dhi_q;
        if (hit_blk)   rd_next = blk_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_act) rd_data <= rd_next;
    end

    assign seq_prot   = ctl_q[4:2];
    assign seq_rnw    = taddr_q[0];
    assign seq_taddr  = taddr_q[7:1];
    assign seq_cmd    = cmd_q;
    assign seq_wdata  = {dhi_q, dlo_q};
    assign unused_ctl = ^ctl_q[7:5];
endmodule

// File: rtl/smbh_host_regs_chk.sv
module smbh_host_regs_chk import smbh_pkg::*; #(
    parameter int ADDR_W    = 8,
    parameter int BLK_DEPTH = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic                         go_bit,
    input logic [2:0]                   rd_hi,
    input logic                         seq_start,
    input logic                         seq_done,
    input logic                         seq_err,
    input logic [7:0]                   stat,
    input logic [$clog2(BLK_DEPTH)-1:0] blk_idx
);
    localparam int IDX_W = $clog2(BLK_DEPTH);

    logic blk_acc, unused_chk;
    assign blk_acc    = (bus_addr == ADDR_W'(OFS_BLK)) && (wr_en || rd_en);
    assign unused_chk = ^stat[6:3];

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> stat[ST_BUSY]);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    p_pending_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFS_CTL) && go_bit && !stat[ST_BUSY] && stat[ST_DEVERR])
        |=> !seq_start);

    p_ok_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_BUSY] && $past(seq_start) && seq_done && !seq_err)
        |=> (stat[ST_BDONE] && stat[ST_INTR] && !stat[ST_BUSY]));

    p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_BUSY] && $past(seq_start) && seq_err)
        |=> (stat[ST_DEVERR] && !stat[ST_BUSY]));

    p_idx_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && blk_idx == IDX_W'(BLK_DEPTH - 1)) |=> (blk_idx == '0));

    p_ctl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && bus_addr == ADDR_W'(OFS_CTL)) |=> (rd_hi == 3'b000));
endmodule

bind smbus_host_regs smbh_host_regs_chk #(.ADDR_W(ADDR_W), .BLK_DEPTH(BLK_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .go_bit   (wr_data[6]),
    .rd_hi    (rd_data[7:5]),
    .seq_start(seq_start),
    .seq_done (seq_done),
    .seq_err  (seq_err),
    .stat     (stat_w),
    .blk_idx  (blk_idx)
);

// File: tb/test_smbus_host_regs.sv
`timescale 1ns/1ps
module test_smbus_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        seq_start, seq_rnw;
    logic [2:0]  seq_prot;
    logic [6:0]  seq_taddr;
    logic [7:0]  seq_cmd;
    logic [15:0] seq_wdata;
    logic        seq_done = 1'b0, seq_err = 1'b0, seq_ld_lo = 1'b0, seq_ld_hi = 1'b0;
    logic [15:0] seq_rdata = '0;

    int n_chk = 0, n_err = 0, starts = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    smbus_host_regs i_smbus_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .seq_start(seq_start), .seq_prot(seq_prot),
        .seq_rnw(seq_rnw), .seq_taddr(seq_taddr), .seq_cmd(seq_cmd), .seq_wdata(seq_wdata),
        .seq_done(seq_done), .seq_err(seq_err), .seq_rdata(seq_rdata),
        .seq_ld_lo(seq_ld_lo), .seq_ld_hi(seq_ld_hi)
    );

    always @(posedge clk) if (rst_n && seq_start) starts++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: push the expected value, then strobe the read
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic resp(input logic d, input logic e, input logic [15:0] data,
                        input logic lo, input logic hi);
        @(negedge clk);
        seq_done = d; seq_err = e; seq_rdata = data; seq_ld_lo = lo; seq_ld_hi = hi;
        @(negedge clk);
        seq_done = 0; seq_err = 0; seq_ld_lo = 0; seq_ld_hi = 0;
    endtask

    // monitor: compare each registered read result with the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !wr_en) begin
                #1;
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL scoreboard: actual=%h expected=<none>", rd_data);
                end else begin
                    chk(tag_q.pop_front(), {8'h00, rd_data}, {8'h00, exp_q.pop_front()});
                end
            end
        end
    end

    function automatic logic [7:0] bval(input int i);
        return 8'(i * 7 + 3);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_data", {8'h00, rd_data}, 16'h0);
        chk("R1 seq_start", {15'h0, seq_start}, 16'h0);
        rd(8'h00, 8'h00, "R1 status");
        rd(8'h02, 8'h00, "R1 control");
        rd(8'h03, 8'h00, "R1 command");
        rd(8'h05, 8'h00, "R1 data-low");
        rd(8'h07, 8'h00, "R1 block");
        // R2 decode
        wr(8'h03, 8'hA5); wr(8'h04, 8'h6B); wr(8'h05, 8'h11); wr(8'h06, 8'h22);
        rd(8'h03, 8'hA5, "R2 command");
        rd(8'h04, 8'h6B, "R2 address");
        rd(8'h05, 8'h11, "R2 data-low");
        rd(8'h06, 8'h22, "R2 data-high");
        wr(8'h01, 8'hFF); wr(8'h09, 8'hFF);
        rd(8'h01, 8'h00, "R2 unmapped 0x01");
        rd(8'h20, 8'h00, "R2 unmapped 0x20");
        rd(8'h03, 8'hA5, "R2 command untouched");
        // R13 engine fields
        wr(8'h02, 8'h0C);
        chk("R13 prot", {13'h0, seq_prot}, 16'h3);
        chk("R13 rnw", {15'h0, seq_rnw}, 16'h1);
        chk("R13 taddr", {9'h0, seq_taddr}, 16'h35);
        chk("R13 cmd", {8'h0, seq_cmd}, 16'hA5);
        chk("R13 wdata", seq_wdata, 16'h2211);
        // R4 control mask
        wr(8'h02, 8'hBF);
        rd(8'h02, 8'h1F, "R4 control read mask");
        chk("R4 no start", 16'(starts), 16'd0);
        // R5 / R6 / R7 successful transfer
        wr(8'h02, 8'h48);
        chk("R5 start pulse", {15'h0, seq_start}, 16'h1);
        rd(8'h00, 8'h01, "R6 busy while waiting");
        chk("R5 single pulse", {15'h0, seq_start}, 16'h0);
        wr(8'h02, 8'h48);
        rd(8'h00, 8'h01, "R6 still busy");
        chk("R5 go while busy ignored", 16'(starts), 16'd1);
        resp(1'b1, 1'b0, 16'hBEEF, 1'b1, 1'b1);
        rd(8'h00, 8'h82, "R7 done flags");
        rd(8'h05, 8'hEF, "R7 data-low loaded");
        rd(8'h06, 8'hBE, "R7 data-high loaded");
        // R3 write-one-to-clear
        wr(8'h00, 8'h02);
        rd(8'h00, 8'h80, "R3 clear intr only");
        wr(8'h00, 8'h01);
        rd(8'h00, 8'h80, "R3 busy bit write no effect");
        wr(8'h00, 8'h80);
        rd(8'h00, 8'h00, "R3 clear byte done");
        // R8 error wins over done
        wr(8'h02, 8'h48);
        resp(1'b1, 1'b1, 16'h1234, 1'b1, 1'b1);
        rd(8'h00, 8'h04, "R8 device error");
        rd(8'h05, 8'hEF, "R8 no load on error");
        // R9 pending error blocks start
        wr(8'h02, 8'h48);
        chk("R9 no start", {15'h0, seq_start}, 16'h0);
        rd(8'h00, 8'h04, "R9 busy cleared, error kept");
        chk("R9 start count", 16'(starts), 16'd2);
        // R10 unsupported protocol
        wr(8'h00, 8'h04);
        wr(8'h02, 8'h50);
        chk("R10 code 4 no start", {15'h0, seq_start}, 16'h0);
        rd(8'h00, 8'h04, "R10 code 4 error");
        wr(8'h00, 8'hFF);
        wr(8'h02, 8'h54);
        chk("R10 code 5 starts", {15'h0, seq_start}, 16'h1);
        resp(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        rd(8'h00, 8'h82, "R10 code 5 done");
        // R11 block buffer wrap
        wr(8'h00, 8'hFF);
        for (int i = 0; i < 32; i++) wr(8'h07, bval(i));
        wr(8'h07, 8'h99);
        rd(8'h02, 8'h14, "R12 control read rewinds");
        rd(8'h07, 8'h99, "R11 entry 0 overwritten after wrap");
        for (int i = 1; i < 32; i++) rd(8'h07, bval(i), "R11 block entry");
        rd(8'h07, 8'h99, "R11 read index wraps");
        // R12 rewind sources
        rd(8'h07, bval(1), "R12 index at 1");
        wr(8'h00, 8'h00);
        rd(8'h07, 8'h99, "R12 status write rewinds");
        rd(8'h07, bval(1), "R12 advance");
        rd(8'h02, 8'h14, "R12 control read");
        rd(8'h07, 8'h99, "R12 control read rewinds");
        chk("R5 total starts", 16'(starts), 16'd3);
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule